// File: doc/BRIEF.md
# Processor Status and Interrupt Gating Unit

This unit holds the processor's 16-bit status word and its exception table base, and decides in each cycle whether the interrupt request level on its input is taken. When a request is taken, it raises a one-cycle accept pulse. In the same cycle it rewrites the status word for exception entry and presents the status value from before the entry, so that the exception frame logic can stack it. It also raises a trace request after each retired instruction while tracing is enabled. It reports the privilege mode and forms the address of the exception vector that the fetch logic must read.

Software reaches both registers through a write port. A return from an exception restores the whole status word on a separate path. Decoding instructions, stacking the frame and reading the vector from memory are done by neighbouring blocks. This unit only signals them and supplies the address.

Status word bit positions, which software and the frame logic depend on: bit 15 trace enable (T), bit 13 supervisor (S), bit 12 master (M), bits 10:8 interrupt mask, bits 4:0 condition codes. Bits 14, 11 and 7:5 are reserved.

Top module: `cpu_status_unit`

## Requirements
- R1: After a synchronous reset the status word reads 0x2700 (S set, mask 7, T clear), the vector base reads 0, and `irq_take` and `trace_req` are low.
- R2: A request at a level from 1 to 6 is taken when it is strictly greater than the mask. A level less than or equal to the mask is not taken. `irq_take` is high for the one cycle after the clock edge that samples the request.
- R3: Level 7 is taken whatever the mask holds, but only on the first cycle it appears after any other level. Holding it at 7 does not take it again.
- R4: Taking an interrupt loads the mask with the taken level, sets S, clears T and M, and presents the previous status word on `sr_saved`, all in the same cycle as `irq_take`.
- R5: Reserved status bits 14, 11 and 7:5 always read as zero, and writes to them have no effect.
- R6: A status write made while S is clear changes only the condition codes in bits 4:0.
- R7: The vector base keeps only bits 31:20 and reads zero in bits 19:0. A vector base write made while S is clear is ignored.
- R8: `vec_addr` equals {base[31:20], 10'b0, vector, 2'b00}, registered, so it is valid one cycle after the vector number is applied.
- R9: `trace_req` is high in the cycle after a retire strobe when T was set, and low otherwise.
- R10: `supervisor` equals the S bit of the current status word.
- R11: A return from an exception loads the status word, with the reserved bits cleared, and can set M and S. When several updates fall in one cycle, an interrupt take wins over the restore, and the restore wins over a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_level | input | 3 | Requested interrupt level, 0 = none |
| sr_wr_en | input | 1 | Software write strobe for the status word |
| sr_wr_data | input | 16 | Status word write data |
| vbr_wr_en | input | 1 | Software write strobe for the vector base |
| vbr_wr_data | input | 32 | Vector base write data |
| insn_retire | input | 1 | One instruction completed this cycle |
| rte_en | input | 1 | Exception-return restore strobe |
| rte_sr | input | 16 | Status word popped from the exception frame |
| exc_vector | input | 8 | Vector number of the exception being entered |
| irq_take | output | 1 | Interrupt accepted (one-cycle pulse) |
| trace_req | output | 1 | Trace exception request |
| supervisor | output | 1 | 1 = supervisor mode, 0 = user mode |
| sr_q | output | 16 | Current status word |
| sr_saved | output | 16 | Status word captured at the last interrupt entry |
| vbr_q | output | 32 | Current vector base |
| vec_addr | output | 32 | Vector fetch address |

## Verification
The hardest case to reach is a cycle in which an interrupt take, an exception-return restore and a software write all arrive together. It only shows its priority order when the mask has first been lowered from supervisor mode, so that the interrupt can actually be taken. The bench writes a mask of zero, then presents a level, a restore and a write in the same cycle, and checks that the entry values win. It then repeats the cycle without the interrupt, to check the restore against the write. The level-7 edge case also needs a set-up sequence: the level is held at 7 to show that it is not taken again, then dropped and raised back to 7 while the mask is 7.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;
  localparam int SR_W   = 16;
  localparam int IPL_W  = 3;
  localparam int SR_T   = 15;
  localparam int SR_S   = 13;
  localparam int SR_M   = 12;
  localparam int IPL_LO = 8;
  localparam int IPL_HI = IPL_LO + IPL_W - 1;
  localparam logic [SR_W-1:0] SR_RW_MASK = 16'hB71F;
  localparam logic [SR_W-1:0] SR_CC_MASK = 16'h001F;
  localparam logic [SR_W-1:0] SR_RESET   = 16'h2700;
  localparam logic [IPL_W-1:0] IPL_NMI   = '1;
endpackage

// File: rtl/cpu_status_irq.sv
module cpu_status_irq
  import cpu_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IPL_W-1:0] irq_level,
  input  logic [IPL_W-1:0] cur_mask,
  input  logic             trace_en,
  input  logic             insn_retire,
  output logic             take_now,
  output logic             irq_take,
  output logic             trace_req
);
  logic [IPL_W-1:0] lvl_prev;

  always_comb begin
    if (irq_level == IPL_NMI) take_now = (lvl_prev != IPL_NMI);
    else                      take_now = (irq_level > cur_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_prev  <= '0;
      irq_take  <= 1'b0;
      trace_req <= 1'b0;
    end else begin
      lvl_prev  <= irq_level;
      irq_take  <= take_now;
      trace_req <= insn_retire & trace_en;
    end
  end
endmodule

// File: rtl/cpu_status_sr.sv
module cpu_status_sr
  import cpu_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             take_now,
  input  logic [IPL_W-1:0] irq_level,
  input  logic             rte_en,
  input  logic [SR_W-1:0]  rte_sr,
  input  logic             wr_en,
  input  logic [SR_W-1:0]  wr_data,
  output logic [SR_W-1:0]  sr,
  output logic [SR_W-1:0]  sr_saved
);
  logic [SR_W-1:0] sr_nxt;

  always_comb begin
    sr_nxt = sr;
    if (take_now) begin
      sr_nxt[IPL_HI:IPL_LO] = irq_level;
      sr_nxt[SR_S] = 1'b1;
      sr_nxt[SR_T] = 1'b0;
      sr_nxt[SR_M] = 1'b0;
    end else if (rte_en) begin
      sr_nxt = rte_sr & SR_RW_MASK;
    end else if (wr_en) begin
      if (sr[SR_S]) sr_nxt = wr_data & SR_RW_MASK;
      else          sr_nxt = (sr & ~SR_CC_MASK) | (wr_data & SR_CC_MASK);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= SR_RESET;
      sr_saved <= '0;
    end else begin
      sr <= sr_nxt;
      if (take_now) sr_saved <= sr;
    end
  end
endmodule

// File: rtl/cpu_status_vbr.sv
module cpu_status_vbr #(
  parameter int ADDR_W   = 32,
  parameter int VBR_KEEP = 12,
  parameter int VEC_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              priv,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [VEC_W-1:0]  vector,
  output logic [ADDR_W-1:0] vbr,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam int LOW_W = ADDR_W - VBR_KEEP;
  localparam int GAP_W = LOW_W - VEC_W - 2;

  logic [VBR_KEEP-1:0] base_hi;
  logic [ADDR_W-1:0]   addr_nxt;

  assign vbr = {base_hi, {LOW_W{1'b0}}};

  generate
    if (GAP_W > 0) begin : g_gap
      assign addr_nxt = {base_hi, {GAP_W{1'b0}}, vector, 2'b00};
    end else begin : g_nogap
      assign addr_nxt = {base_hi, vector[LOW_W-3:0], 2'b00};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi  <= '0;
      vec_addr <= '0;
    end else begin
      if (wr_en && priv) base_hi <= wr_data[ADDR_W-1:LOW_W];
      vec_addr <= addr_nxt;
    end
  end
endmodule

// File: rtl/cpu_status_unit.sv
module cpu_status_unit
  import cpu_status_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int VBR_KEEP = 12,
  parameter int VEC_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IPL_W-1:0]  irq_level,
  input  logic              sr_wr_en,
  input  logic [SR_W-1:0]   sr_wr_data,
  input  logic              vbr_wr_en,
  input  logic [ADDR_W-1:0] vbr_wr_data,
  input  logic              insn_retire,
  input  logic              rte_en,
  input  logic [SR_W-1:0]   rte_sr,
  input  logic [VEC_W-1:0]  exc_vector,
  output logic              irq_take,
  output logic              trace_req,
  output logic              supervisor,
  output logic [SR_W-1:0]   sr_q,
  output logic [SR_W-1:0]   sr_saved,
  output logic [ADDR_W-1:0] vbr_q,
  output logic [ADDR_W-1:0] vec_addr
);
  logic take_now;

  cpu_status_irq u_irq (
    .clk, .rst, .irq_level,
    .cur_mask(sr_q[IPL_HI:IPL_LO]),
    .trace_en(sr_q[SR_T]),
    .insn_retire, .take_now, .irq_take, .trace_req
  );

  cpu_status_sr u_sr (
    .clk, .rst, .take_now, .irq_level, .rte_en, .rte_sr,
    .wr_en(sr_wr_en), .wr_data(sr_wr_data),
    .sr(sr_q), .sr_saved
  );

  cpu_status_vbr #(.ADDR_W(ADDR_W), .VBR_KEEP(VBR_KEEP), .VEC_W(VEC_W)) u_vbr (
    .clk, .rst, .wr_en(vbr_wr_en), .priv(sr_q[SR_S]),
    .wr_data(vbr_wr_data), .vector(exc_vector),
    .vbr(vbr_q), .vec_addr
  );

  assign supervisor = sr_q[SR_S];
endmodule

// File: rtl/cpu_status_chk.sv
module cpu_status_chk (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  irq_level,
  input logic        insn_retire,
  input logic        irq_take,
  input logic        trace_req,
  input logic [15:0] sr_q,
  input logic [15:0] sr_saved,
  input logic [31:0] vbr_q
);
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (irq_level != 3'd7 && irq_level <= sr_q[10:8]) |=> !irq_take); // R2
  AST_NMI_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq_level == 3'd7 && $past(irq_level) == 3'd7 && !$past(rst)) |=> !irq_take); // R3
  AST_ENTRY_STATE: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (sr_q[10:8] == $past(irq_level) && sr_q[13] && !sr_q[12] && !sr_q[15])); // R4
  AST_ENTRY_SAVED: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> sr_saved == $past(sr_q)); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sr_q & 16'h48E0) == 16'h0000); // R5
  AST_VBR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    vbr_q[19:0] == 20'h0); // R7
  AST_TRACE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    trace_req |-> ($past(insn_retire) && $past(sr_q[15]))); // R9
endmodule

bind cpu_status_unit cpu_status_chk u_chk (
  .clk, .rst, .irq_level, .insn_retire, .irq_take, .trace_req,
  .sr_q, .sr_saved, .vbr_q
);

// File: tb/cpu_status_unit_test.sv
module cpu_status_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  irq_level = '0;
  logic        sr_wr_en = 1'b0;
  logic [15:0] sr_wr_data = '0;
  logic        vbr_wr_en = 1'b0;
  logic [31:0] vbr_wr_data = '0;
  logic        insn_retire = 1'b0;
  logic        rte_en = 1'b0;
  logic [15:0] rte_sr = '0;
  logic [7:0]  exc_vector = '0;
  logic        irq_take, trace_req, supervisor;
  logic [15:0] sr_q, sr_saved;
  logic [31:0] vbr_q, vec_addr;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cpu_status_unit uut (
    .clk, .rst, .irq_level, .sr_wr_en, .sr_wr_data, .vbr_wr_en, .vbr_wr_data,
    .insn_retire, .rte_en, .rte_sr, .exc_vector, .irq_take, .trace_req,
    .supervisor, .sr_q, .sr_saved, .vbr_q, .vec_addr
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sr_write(logic [15:0] v);
    sr_wr_en = 1'b1; sr_wr_data = v;
    step();
    sr_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sr", 32'(sr_q), 32'h2700);
    chk("R1 vbr", vbr_q, 32'h0);
    chk("R1 take", 32'(irq_take), 32'h0);
    chk("R1 trace", 32'(trace_req), 32'h0);
    chk("R10 sup", 32'(supervisor), 32'h1);
  endtask

  task automatic t_mask();
    irq_level = 3'd3; step();
    chk("R2 masked", 32'(irq_take), 32'h0);
    irq_level = 3'd0;
    sr_write(16'h2300);
    irq_level = 3'd3; step();
    chk("R2 equal", 32'(irq_take), 32'h0);
    irq_level = 3'd5; step();
    chk("R2 take", 32'(irq_take), 32'h1);
    chk("R4 sr", 32'(sr_q), 32'h2500);
    chk("R4 saved", 32'(sr_saved), 32'h2300);
    step();
    chk("R2 pulse", 32'(irq_take), 32'h0);
    irq_level = 3'd0; step();
  endtask

  task automatic t_level7();
    irq_level = 3'd7; step();
    chk("R3 take", 32'(irq_take), 32'h1);
    chk("R3 mask", 32'(sr_q), 32'h2700);
    step();
    chk("R3 held", 32'(irq_take), 32'h0);
    irq_level = 3'd0; step();
    irq_level = 3'd7; step();
    chk("R3 retake", 32'(irq_take), 32'h1);
    irq_level = 3'd0; step();
  endtask

  task automatic t_reserved();
    sr_write(16'hFFFF);
    chk("R5 rsvd", 32'(sr_q), 32'hB71F);
    sr_write(16'h2700);
  endtask

  task automatic t_trace();
    sr_write(16'hA700);
    insn_retire = 1'b1; step();
    chk("R9 on", 32'(trace_req), 32'h1);
    insn_retire = 1'b0; step();
    chk("R9 idle", 32'(trace_req), 32'h0);
    sr_write(16'h2700);
    insn_retire = 1'b1; step();
    chk("R9 off", 32'(trace_req), 32'h0);
    insn_retire = 1'b0;
  endtask

  task automatic t_user();
    sr_write(16'h0000);
    chk("R10 user", 32'(supervisor), 32'h0);
    sr_write(16'hFFFF);
    chk("R6 ccr only", 32'(sr_q), 32'h001F);
    vbr_wr_en = 1'b1; vbr_wr_data = 32'hFFFF_FFFF; step();
    vbr_wr_en = 1'b0;
    chk("R7 user ignore", vbr_q, 32'h0);
  endtask

  task automatic t_rte();
    rte_en = 1'b1; rte_sr = 16'hFF05; step();
    rte_en = 1'b0;
    chk("R11 restore", 32'(sr_q), 32'hB705);
    chk("R10 back", 32'(supervisor), 32'h1);
  endtask

  task automatic t_vbr();
    vbr_wr_en = 1'b1; vbr_wr_data = 32'h123A_BCDE; step();
    vbr_wr_en = 1'b0;
    chk("R7 keep", vbr_q, 32'h1230_0000);
    exc_vector = 8'h40; step();
    chk("R8 addr", vec_addr, 32'h1230_0100);
    exc_vector = 8'hFF; step();
    chk("R8 addr max", vec_addr, 32'h1230_03FC);
  endtask

  task automatic t_prio();
    sr_write(16'h2000);
    irq_level = 3'd2; rte_en = 1'b1; rte_sr = 16'h1000;
    sr_wr_en = 1'b1; sr_wr_data = 16'h8000;
    step();
    chk("R11 irq wins", 32'(sr_q), 32'h2200);
    chk("R11 saved", 32'(sr_saved), 32'h2000);
    irq_level = 3'd0; rte_sr = 16'h2100; sr_wr_data = 16'h2400;
    step();
    rte_en = 1'b0; sr_wr_en = 1'b0;
    chk("R11 rte wins", 32'(sr_q), 32'h2100);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_mask();
    t_level7();
    t_reserved();
    t_trace();
    t_user();
    t_rte();
    t_vbr();
    t_prio();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule